// File: doc/BRIEF.md
# Octal Converter Code Register Bank

This block is the digital front end of an eight-channel, 14-bit voltage converter. A host drives a parallel data word, a 3-bit channel number and two active-low strobes (chip select and write). Every completed write lands in one of eight input registers. A separate active-low load input copies the whole input layer into the eight converter registers at once. That lets a host stage new codes for several channels and then switch them all together.

The converter codes are straight binary and are presented to the analog stage on a flat output bus. A per-channel flag tells the output stage whether to drive the converted code or the externally supplied offset/ground level. An asynchronous active-low clear raises all eight flags at once. The clear leaves both register layers untouched, so releasing it restores the stored codes.

The bus strobes, the load input and the bus address and data are resampled on the block clock. A write is taken on the synchronised rising edge of the write strobe. Holding load low makes each write pass straight through to its converter register.

Top module: `octal_dac_regbank`

## Requirements
- R1: After reset every input register and every converter register holds zero, and all offset-select flags are 0 while clear is high.
- R2: Channel number 0 selects channel A and 7 selects channel H, in straight binary order. The code of channel k appears on `dac_code[k*14 +: 14]`. A write changes only the addressed input register.
- R3: A write happens only if chip select is low while the write strobe is low. The word held on the bus during the low phase of the write strobe is captured when the strobe rises. A strobe pulse with chip select high changes no register.
- R4: While load is high, the converter registers keep their values, and writes to input registers do not reach `dac_code`.
- R5: While load is low, every converter register is loaded from its matching input register.
- R6: With load held low, a write updates the addressed converter register in the same cycle as its input register, so the written word appears on `dac_code`.
- R7: While clear is low, all eight bits of `chan_offset_sel` are 1 with no clock edge needed. Neither register layer changes because of clear.
- R8: When clear returns high, `chan_offset_sel` returns to all zeros and `dac_code` shows the codes stored before and during the clear.
- R9: Codes are straight binary: bit 13 is the MSB and bit 0 the LSB. 14'h0000 (bottom of scale) and 14'h3FFF (full scale minus one LSB) pass unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe; data taken on its rising edge |
| bus_addr | input | 3 | Channel number, 0 = A to 7 = H |
| bus_data | input | 14 | Code word, bit 13 MSB |
| load_n | input | 1 | Active-low, level-sensitive transfer of all input registers |
| clear_n | input | 1 | Asynchronous active-low clear of the output selection |
| dac_code | output | 112 | Eight 14-bit converter codes, channel k at bits k*14+13 down to k*14 |
| chan_offset_sel | output | 8 | Per channel: 1 = drive offset/ground level, 0 = drive code |

## Verification
The embedded properties check, on every cycle, four behaviours of the register layers:
- a write leaves every input register except the addressed one unchanged;
- a strobe with chip select high disturbs no input register;
- the converter layer holds still while load is high;
- with load low, a detected write arrives at its converter register one cycle later.

Some behaviours can only be shown by the bench's scenarios:
- the strobe timing at the pins, that is, which bus word is captured relative to the rising strobe;
- the group transfer of staged codes after several writes;
- the asynchronous reaction of the flags to clear and the recovery of the stored codes when clear is released;
- the extreme code values.

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank #(
  parameter int CH = 8,
  parameter int W  = 14,
  localparam int AW = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs_n,
  input  logic            bus_wr_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [W-1:0]    bus_data,
  input  logic            load_n,
  input  logic            clear_n,
  output logic [CH*W-1:0] dac_code,
  output logic [CH-1:0]   chan_offset_sel
);

  logic [2:0]    wr_s, cs_s;
  logic [1:0]    ld_s;
  logic [AW-1:0] a_p [3];
  logic [W-1:0]  d_p [3];
  logic [W-1:0]  in_q  [CH];
  logic [W-1:0]  dac_q [CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s <= '1;
      cs_s <= '1;
      ld_s <= '1;
      for (int k = 0; k < 3; k++) begin
        a_p[k] <= '0;
        d_p[k] <= '0;
      end
    end else begin
      wr_s <= {wr_s[1:0], bus_wr_n};
      cs_s <= {cs_s[1:0], bus_cs_n};
      ld_s <= {ld_s[0], load_n};
      a_p[0] <= bus_addr;
      d_p[0] <= bus_data;
      for (int k = 1; k < 3; k++) begin
        a_p[k] <= a_p[k-1];
        d_p[k] <= d_p[k-1];
      end
    end
  end

  // wr_s[2] and cs_s[2] hold the last sample taken while the strobe was low.
  // The address and data pipes are aligned to that same sample.
  logic we, ld_act;
  assign we     = wr_s[1] & ~wr_s[2] & ~cs_s[2];
  assign ld_act = ~ld_s[1];

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic hit;
    assign hit = we && (a_p[2] == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end else begin
        if (hit) in_q[i] <= d_p[2];
        if (ld_act) dac_q[i] <= hit ? d_p[2] : in_q[i];
      end
    end

    assign dac_code[i*W +: W] = dac_q[i];

    p_only_addressed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && a_p[2] != AW'(i)) |=> $stable(in_q[i]));

    p_no_write_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s[2] |=> $stable(in_q[i]));

    p_hold_without_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_act |=> $stable(dac_q[i]));
  end

  p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ld_act) |=> dac_q[$past(a_p[2])] == $past(d_p[2]));

  assign chan_offset_sel = {CH{~clear_n}};

endmodule

// File: tb/octal_dac_regbank_test.sv
module octal_dac_regbank_test;
  localparam int CH = 8;
  localparam int W  = 14;

  logic clk = 0;
  logic rst_n = 0;
  logic cs_n = 1, wr_n = 1, load_n = 1, clear_n = 1;
  logic [2:0] addr = '0;
  logic [W-1:0] data = '0;
  logic [CH*W-1:0] dac_code;
  logic [CH-1:0] offs;

  int checks = 0, fails = 0;
  logic [W-1:0] exp_in [CH];
  logic [W-1:0] exp_dac [CH];

  always #4 clk = ~clk;

  octal_dac_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n),
    .bus_addr(addr), .bus_data(data), .load_n(load_n), .clear_n(clear_n),
    .dac_code(dac_code), .chan_offset_sel(offs)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_codes(input string req);
    for (int i = 0; i < CH; i++) begin
      checks++;
      if (dac_code[i*W +: W] !== exp_dac[i]) begin
        fails++;
        $display("FAIL %s ch%0d code actual=%h expected=%h", req, i, dac_code[i*W +: W], exp_dac[i]);
      end
    end
  endtask

  task automatic chk_flags(input string req, input logic [CH-1:0] e);
    checks++;
    if (offs !== e) begin
      fails++;
      $display("FAIL %s flags actual=%b expected=%b", req, offs, e);
    end
  endtask

  // Data is changed to junk right after the strobe rises; the captured word must be the earlier one.
  task automatic bus_write(input int ch, input logic [W-1:0] v, input logic sel);
    @(negedge clk);
    addr = 3'(ch); data = v; cs_n = ~sel;
    idle(1);
    wr_n = 0;
    idle(3);
    wr_n = 1;
    data = ~v; addr = 3'(ch + 1);
    idle(1);
    cs_n = 1;
    idle(5);
    if (sel) begin
      exp_in[ch] = v;
      if (!load_n) exp_dac[ch] = v;
    end
  endtask

  task automatic pulse_load();
    load_n = 0;
    idle(4);
    load_n = 1;
    idle(4);
    for (int i = 0; i < CH; i++) exp_dac[i] = exp_in[i];
  endtask

  task automatic t_reset();
    chk_codes("R1");
    chk_flags("R1", '0);
  endtask

  task automatic t_stage_then_load();
    for (int i = 0; i < CH; i++) bus_write(i, W'(16'h0101 * (i + 1)), 1'b1);
    chk_codes("R4");
    pulse_load();
    chk_codes("R5");
    chk_codes("R2");
  endtask

  task automatic t_single_channel();
    bus_write(5, 14'h2A5C, 1'b1);
    pulse_load();
    chk_codes("R2");
  endtask

  task automatic t_no_select();
    bus_write(3, 14'h1234, 1'b0);
    pulse_load();
    chk_codes("R3");
  endtask

  task automatic t_pass_through();
    load_n = 0;
    idle(4);
    bus_write(0, 14'h0000, 1'b1);
    chk_codes("R9");
    bus_write(7, 14'h3FFF, 1'b1);
    chk_codes("R6");
    bus_write(2, 14'h2000, 1'b1);
    bus_write(6, 14'h1FFF, 1'b1);
    chk_codes("R9");
    load_n = 1;
    idle(4);
  endtask

  task automatic t_clear();
    clear_n = 0;
    #1;
    chk_flags("R7", '1);
    idle(2);
    chk_codes("R7");
    bus_write(4, 14'h0F0F, 1'b1);
    chk_codes("R4");
    pulse_load();
    chk_flags("R7", '1);
    clear_n = 1;
    #1;
    chk_flags("R8", '0);
    idle(1);
    chk_codes("R8");
  endtask

  initial begin
    for (int i = 0; i < CH; i++) begin
      exp_in[i] = '0;
      exp_dac[i] = '0;
    end
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_stage_then_load();
    t_single_channel();
    t_no_select();
    t_pass_through();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule